// File: doc/BRIEF.md
# Invertible Stochastic Ripple-Carry Adder

This block is an N-bit adder (4 bits by default) whose every bit is a stochastic binary unit. Each unit re-draws its own output at a fixed private interval. On each draw it compares a fresh pseudo-random byte with a logistic-shaped acceptance level. That level is derived from the energy change the unit would cause in its local adder stage. Stage 0 is a half adder and each higher stage is a full adder. The energy of a stage is the square of `a + b + carry_in - sum - 2*carry_out`, so its zero-energy states are exactly the truth table of that stage.

Stages are linked one way only. The carry-in of stage g reads the carry-out unit of stage g-1, but stage g never enters the energy seen by stage g-1. Any operand bit, sum bit or the final carry can be clamped. If A and B are clamped, the free sum bits settle on A+B (forward use). If the 5-bit sum is clamped, the free operand bits wander among the operand pairs that produce it (inverted use). A global strength input scales every energy change, which sweeps the circuit from coin-flipping to near-deterministic. A sample strobe marks regular instants at which the live states can be histogrammed.

Each unit cycles through a small state machine. HOLD is the clamped state: the unit copies its forced value every cycle. COUNT is the free state: it counts toward the unit's interval. FIRE lasts one cycle and performs the draw. The transitions are: COUNT→FIRE when the count reaches the interval, FIRE→COUNT after the draw, COUNT/FIRE→HOLD when the clamp is raised, and HOLD→COUNT when the clamp drops. The sampler has two states. SETTLE waits out the settling time after reset, and SETTLE→RUN happens when that time expires. RUN then pulses the strobe once per period and never leaves.

Top module: `pbit_inv_adder`

## Requirements
- R1: While reset is asserted, all of `a_state`, `b_state` and `s_state` are 0 and `sample_stb` is 0.
- R2: In forward use (A and B clamped, sum free, strength 4), `s_state` equals A+B in at least 60% of strobe samples after settling, for several distinct operand pairs.
- R3: A clamped operand bit shows its clamp value on `a_state`/`b_state` on the cycle after the clamp is applied; bit i of the clamp vectors maps to bit i of the operand.
- R4: A clamped sum bit shows its clamp value on `s_state` on the next cycle; `s_state[N]` is the final carry-out and is clamped by `s_clamp_en[N]`.
- R5: In inverted use (all 5 sum bits clamped to 23, operands free, strength 3), at least 25% of samples satisfy A+B=23, and each of the 8 pairs (A=8+p, B=15-p, p=0..7) appears at least once.
- R6: Carry links are one-way: with A=1 and B=1 clamped and only the final carry clamped to 1 (strength 4), `s_state[2:0]` still equals 2 in at least 60% of samples.
- R7: At strength 0 every free unit draws with probability one half, so with A=10 and B=13 clamped the sum equals 23 in fewer than 30% of samples.
- R8: After the first strobe, `sample_stb` is a one-cycle pulse repeating exactly every SAMPLE_IVL cycles.
- R9: The first strobe appears SETTLE+SAMPLE_IVL cycles after reset release, and none earlier.
- R10: Unit k (k = 4*stage + role, roles a,b,sum,carry = 0..3) re-draws every MEAN_IVL - D + ((7k) mod (2D+1)) cycles with D = 3*MEAN_IVL/10, so no free unit changes state twice within MEAN_IVL - D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strength | input | STR_W | Inverse-temperature multiplier applied to every energy change |
| a_clamp_en | input | N | Per-bit clamp enable for operand A |
| a_clamp_val | input | N | Forced values for operand A |
| b_clamp_en | input | N | Per-bit clamp enable for operand B |
| b_clamp_val | input | N | Forced values for operand B |
| s_clamp_en | input | N+1 | Per-bit clamp enable for the sum; top bit is the final carry |
| s_clamp_val | input | N+1 | Forced values for the sum |
| a_state | output | N | Live states of the operand A units |
| b_state | output | N | Live states of the operand B units |
| s_state | output | N+1 | Live states of the sum units and final carry |
| sample_stb | output | 1 | One-cycle strobe marking a sample instant |

## Verification
The hardest situation to reach is the inverted mode's full coverage. Each move between valid operand pairs has to pass through a state one energy unit above the ground. A bench that waits for a specific pair therefore depends on rare excitations. The bench clamps the sum to 23 at a middle strength, where such excursions are frequent but brief. It shortens the unit intervals through the parameter, so that many thousands of draws fit in the run. It then histograms every strobe sample against the 8 pairs computed arithmetically.

// File: rtl/pbit_adder_pkg.sv
package pbit_adder_pkg;

    typedef enum logic [1:0] {PB_HOLD, PB_COUNT, PB_FIRE} pb_phase_e;
    typedef enum logic       {SMP_SETTLE, SMP_RUN}        smp_phase_e;

    localparam int FIELD_W = 8;   // signed energy-change width
    localparam int DRAW_W  = 8;   // random byte width
    localparam int LFSR_W  = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam int ROLES   = 4;   // a, b, sum, carry

    // Weight of each role in the stage balance a+b+cin-sum-2*cout.
    function automatic logic signed [FIELD_W-1:0] role_coef(input int role);
        case (role)
            0, 1:    return FIELD_W'(1);
            2:       return -FIELD_W'(1);
            default: return -FIELD_W'(2);
        endcase
    endfunction

    // E(x=1) - E(x=0) for a squared-balance stage energy.
    function automatic logic signed [FIELD_W-1:0] energy_step(
        input logic signed [FIELD_W-1:0] bal,
        input logic signed [FIELD_W-1:0] coef,
        input logic                      x);
        int rest;
        rest = int'(bal) - (x ? int'(coef) : 0);
        return FIELD_W'(2 * int'(coef) * rest + int'(coef) * int'(coef));
    endfunction

    // Base-2 logistic: probability of drawing 1, scaled to 2^DRAW_W.
    function automatic logic [DRAW_W:0] accept_level(input int h);
        int k;
        if (h >= 0) begin
            k = h;
            if (k >= DRAW_W) return (DRAW_W+1)'(1 << DRAW_W);
            return (DRAW_W+1)'((1 << DRAW_W) - ((1 << (DRAW_W-1)) >> k));
        end
        k = -h;
        if (k >= DRAW_W) return '0;
        return (DRAW_W+1)'((1 << (DRAW_W-1)) >> k);
    endfunction

    // Per-unit redraw interval spread +-30% around the mean.
    function automatic int unit_interval(input int idx, input int mean);
        int spr;
        spr = (mean * 3) / 10;
        return mean - spr + ((idx * 7) % (2 * spr + 1));
    endfunction

    function automatic logic [LFSR_W-1:0] unit_seed(input int idx);
        return LFSR_W'(32'hACE1 + idx * 32'h3C6F) | LFSR_W'(1);
    endfunction

endpackage

// File: rtl/pbit_cell.sv
module pbit_cell
    import pbit_adder_pkg::*;
#(
    parameter int                IVL   = 200,
    parameter logic [LFSR_W-1:0] SEED  = 16'h0001,
    parameter int                STR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hold,
    input  logic                      hold_val,
    input  logic signed [FIELD_W-1:0] de,
    input  logic [STR_W-1:0]          strength,
    output logic                      spin
);

    localparam int              CNT_W = (IVL > 2) ? $clog2(IVL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IVL - 2);

    pb_phase_e          phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [LFSR_W-1:0]  lfsr_q;
    logic [LFSR_W-1:0]  lfsr_nxt;
    logic [DRAW_W:0]    level;
    logic               draw;
    int                 h;

    always_comb begin
        h        = -(int'(de) * int'(strength));
        level    = accept_level(h);
        draw     = ({1'b0, lfsr_q[DRAW_W-1:0]} < level);
        lfsr_nxt = lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_TAPS) : (lfsr_q >> 1);
    end

    // State register: interval sequencing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PB_COUNT;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PB_HOLD: begin
                    if (!hold) begin
                        phase_q <= PB_COUNT;
                        cnt_q   <= '0;
                    end
                end
                PB_COUNT: begin
                    if (hold) begin
                        phase_q <= PB_HOLD;
                    end else if (cnt_q == LAST) begin
                        phase_q <= PB_FIRE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PB_FIRE: begin
                    phase_q <= hold ? PB_HOLD : PB_COUNT;
                    cnt_q   <= '0;
                end
                default: phase_q <= PB_COUNT;
            endcase
        end
    end

    // Output register: spin and random source.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spin   <= 1'b0;
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= lfsr_nxt;
            if (hold) begin
                spin <= hold_val;
            end else if (phase_q == PB_FIRE) begin
                spin <= draw;
            end
        end
    end

endmodule

// File: rtl/pbit_stage.sv
module pbit_stage
    import pbit_adder_pkg::*;
#(
    parameter bit HALF     = 1'b0,
    parameter int BASE     = 0,
    parameter int MEAN_IVL = 200,
    parameter int STR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carry_in,
    input  logic [STR_W-1:0]  strength,
    input  logic [ROLES-1:0]  hold,
    input  logic [ROLES-1:0]  hold_val,
    output logic [ROLES-1:0]  spins
);

    logic                      cin_eff;
    logic signed [FIELD_W-1:0] bal;

    assign cin_eff = HALF ? 1'b0 : carry_in;

    always_comb begin
        bal = FIELD_W'(int'(spins[0]) + int'(spins[1]) + int'(cin_eff)
                       - int'(spins[2]) - 2 * int'(spins[3]));
    end

    for (genvar k = 0; k < ROLES; k++) begin : g_cell
        localparam logic signed [FIELD_W-1:0] COEF = role_coef(k);
        logic signed [FIELD_W-1:0] de;

        assign de = energy_step(bal, COEF, spins[k]);

        pbit_cell #(
            .IVL   (unit_interval(BASE + k, MEAN_IVL)),
            .SEED  (unit_seed(BASE + k)),
            .STR_W (STR_W)
        ) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (hold[k]),
            .hold_val (hold_val[k]),
            .de       (de),
            .strength (strength),
            .spin     (spins[k])
        );
    end

endmodule

// File: rtl/sample_timer.sv
module sample_timer
    import pbit_adder_pkg::*;
#(
    parameter int SETTLE = 256,
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb
);

    localparam int CW = $clog2(((SETTLE > PERIOD) ? SETTLE : PERIOD) + 1);

    smp_phase_e     phase_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= SMP_SETTLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                SMP_SETTLE: begin
                    if (cnt_q == CW'(SETTLE - 1)) begin
                        phase_q <= SMP_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SMP_RUN: begin
                    cnt_q <= (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
                end
                default: phase_q <= SMP_SETTLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb <= 1'b0;
        else        stb <= (phase_q == SMP_RUN) && (cnt_q == CW'(PERIOD - 1));
    end

endmodule

// File: rtl/pbit_inv_adder.sv
module pbit_inv_adder
    import pbit_adder_pkg::*;
#(
    parameter int N          = 4,
    parameter int MEAN_IVL   = 200,
    parameter int SETTLE     = 256,
    parameter int SAMPLE_IVL = 64,
    parameter int STR_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STR_W-1:0] strength,
    input  logic [N-1:0]     a_clamp_en,
    input  logic [N-1:0]     a_clamp_val,
    input  logic [N-1:0]     b_clamp_en,
    input  logic [N-1:0]     b_clamp_val,
    input  logic [N:0]       s_clamp_en,
    input  logic [N:0]       s_clamp_val,
    output logic [N-1:0]     a_state,
    output logic [N-1:0]     b_state,
    output logic [N:0]       s_state,
    output logic             sample_stb
);

    logic [N-1:0] carry;
    logic [N-1:0] cin_w;

    for (genvar g = 0; g < N; g++) begin : g_stage
        logic [ROLES-1:0] hold_g;
        logic [ROLES-1:0] val_g;
        logic [ROLES-1:0] spins_g;

        assign hold_g[2:0] = {s_clamp_en[g],  b_clamp_en[g],  a_clamp_en[g]};
        assign val_g[2:0]  = {s_clamp_val[g], b_clamp_val[g], a_clamp_val[g]};

        if (g == N - 1) begin : g_last
            assign hold_g[3] = s_clamp_en[N];
            assign val_g[3]  = s_clamp_val[N];
        end else begin : g_inner
            assign hold_g[3] = 1'b0;
            assign val_g[3]  = 1'b0;
        end

        // One-way link: only the lower carry-out unit feeds this stage.
        if (g == 0) begin : g_lsb
            assign cin_w[g] = 1'b0;
        end else begin : g_upper
            assign cin_w[g] = carry[g-1];
        end

        pbit_stage #(
            .HALF     (g == 0),
            .BASE     (ROLES * g),
            .MEAN_IVL (MEAN_IVL),
            .STR_W    (STR_W)
        ) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .carry_in (cin_w[g]),
            .strength (strength),
            .hold     (hold_g),
            .hold_val (val_g),
            .spins    (spins_g)
        );

        assign a_state[g] = spins_g[0];
        assign b_state[g] = spins_g[1];
        assign s_state[g] = spins_g[2];
        assign carry[g]   = spins_g[3];
    end

    assign s_state[N] = carry[N-1];

    sample_timer #(
        .SETTLE (SETTLE),
        .PERIOD (SAMPLE_IVL)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (sample_stb)
    );

endmodule

// File: rtl/pbit_inv_adder_chk.sv
module pbit_inv_adder_chk #(
    parameter int N          = 4,
    parameter int SETTLE     = 256,
    parameter int SAMPLE_IVL = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] a_clamp_en,
    input logic [N-1:0] a_clamp_val,
    input logic [N-1:0] b_clamp_en,
    input logic [N-1:0] b_clamp_val,
    input logic [N:0]   s_clamp_en,
    input logic [N:0]   s_clamp_val,
    input logic [N-1:0] a_state,
    input logic [N-1:0] b_state,
    input logic [N:0]   s_state,
    input logic         sample_stb
);

    localparam int FIRST = SETTLE + SAMPLE_IVL;

    int cyc_q;
    int gap_q;
    bit seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= 0;
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else begin
            if (cyc_q < FIRST) cyc_q <= cyc_q + 1;
            if (sample_stb) begin
                a_r9_no_early_stb : assert (cyc_q >= FIRST)
                    else $error("strobe before settling ended");
                if (seen_q) begin
                    a_r8_stb_period : assert (gap_q == SAMPLE_IVL)
                        else $error("strobe gap %0d", gap_q);
                end
                seen_q <= 1'b1;
                gap_q  <= 1;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    a_r3_clamp_a : assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((a_state & $past(a_clamp_en)) == ($past(a_clamp_val) & $past(a_clamp_en))));

    a_r3_clamp_b : assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((b_state & $past(b_clamp_en)) == ($past(b_clamp_val) & $past(b_clamp_en))));

    a_r4_clamp_s : assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((s_state & $past(s_clamp_en)) == ($past(s_clamp_val) & $past(s_clamp_en))));

    a_r8_stb_single : assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

endmodule

bind pbit_inv_adder pbit_inv_adder_chk #(
    .N          (N),
    .SETTLE     (SETTLE),
    .SAMPLE_IVL (SAMPLE_IVL)
) chk_i (.*);

// File: tb/pbit_inv_adder_tb_top.sv
module pbit_inv_adder_tb_top;

    localparam int N     = 4;
    localparam int MEAN  = 20;
    localparam int SETL  = 64;
    localparam int SIVL  = 32;
    localparam int MIN_GAP = MEAN - (MEAN * 3) / 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   strength = '0;
    logic [N-1:0] a_clamp_en = '0, a_clamp_val = '0;
    logic [N-1:0] b_clamp_en = '0, b_clamp_val = '0;
    logic [N:0]   s_clamp_en = '0, s_clamp_val = '0;
    logic [N-1:0] a_state, b_state;
    logic [N:0]   s_state;
    logic         sample_stb;

    int vectors = 0;
    int miscmp  = 0;

    always #10 clk = ~clk;

    pbit_inv_adder #(
        .N(N), .MEAN_IVL(MEAN), .SETTLE(SETL), .SAMPLE_IVL(SIVL), .STR_W(3)
    ) dut_i (
        .clk, .rst_n, .strength,
        .a_clamp_en, .a_clamp_val, .b_clamp_en, .b_clamp_val,
        .s_clamp_en, .s_clamp_val,
        .a_state, .b_state, .s_state, .sample_stb
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Strobe spacing monitor (R8).
    bit gap_on = 1'b0, gap_seen = 1'b0;
    int gap_cnt = 0, gap_bad = 0, gap_last = 0;
    always @(negedge clk) if (gap_on) begin
        gap_cnt++;
        if (sample_stb) begin
            if (gap_seen && gap_cnt != SIVL) begin
                gap_bad++;
                gap_last = gap_cnt;
            end
            gap_seen = 1'b1;
            gap_cnt  = 0;
        end
    end

    // Change-spacing monitor on free sum units (R10).
    bit chg_on = 1'b0;
    int chg_t = 0, chg_n = 0, chg_bad = 0, chg_min = 1000000;
    int last_chg [N+1];
    logic [N:0] prev_s;
    always @(negedge clk) begin
        if (chg_on) begin
            for (int i = 0; i <= N; i++) begin
                if (s_state[i] != prev_s[i]) begin
                    if (last_chg[i] >= 0 && chg_t - last_chg[i] < chg_min)
                        chg_min = chg_t - last_chg[i];
                    if (last_chg[i] >= 0 && chg_t - last_chg[i] < MIN_GAP)
                        chg_bad++;
                    chg_n++;
                    last_chg[i] = chg_t;
                end
            end
            chg_t++;
        end
        prev_s = s_state;
    end

    task automatic wait_stb();
        do @(negedge clk); while (!sample_stb);
    endtask

    task automatic sample_match(input int n, input int exp_s, input logic [N:0] mask,
                                output int good);
        good = 0;
        for (int i = 0; i < n; i++) begin
            wait_stb();
            if ((s_state & mask) == (N+1)'(exp_s) & mask) good++;
        end
    endtask

    int hist [8];
    task automatic sample_inv(input int n, output int consistent);
        consistent = 0;
        for (int i = 0; i < n; i++) begin
            wait_stb();
            if (int'(a_state) + int'(b_state) == 23) begin
                consistent++;
                hist[int'(a_state) - 8]++;
            end
        end
    endtask

    task automatic forward(input int a, input int b);
        int good;
        @(negedge clk);
        a_clamp_en = '1; a_clamp_val = N'(a);
        b_clamp_en = '1; b_clamp_val = N'(b);
        repeat (300) @(negedge clk);
        sample_match(150, a + b, '1, good);
        check(good * 10 >= 150 * 6, "R2", $sformatf("forward %0d+%0d hits", a, b), good, 90);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        vectors++;
        miscmp++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        int n, good, cons;
        for (int i = 0; i <= N; i++) last_chg[i] = -1;
        for (int p = 0; p < 8; p++) hist[p] = 0;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(a_state == 0 && b_state == 0 && s_state == 0, "R1", "states in reset",
              int'({a_state, b_state, s_state}), 0);
        check(sample_stb == 1'b0, "R1", "strobe in reset", int'(sample_stb), 0);

        // R9: first strobe position
        rst_n  = 1'b1;
        gap_on = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!sample_stb);
        check(n == SETL + SIVL, "R9", "first strobe cycle", n, SETL + SIVL);

        // R3: operand clamps
        a_clamp_en = '1; a_clamp_val = 4'd10;
        b_clamp_en = '1; b_clamp_val = 4'd13;
        @(negedge clk);
        check(a_state == 4'd10, "R3", "clamped A", int'(a_state), 10);
        check(b_state == 4'd13, "R3", "clamped B", int'(b_state), 13);
        a_clamp_val = 4'd5;
        @(negedge clk);
        check(a_state == 4'd5, "R3", "re-clamped A", int'(a_state), 5);

        // R4: sum clamps including final carry
        s_clamp_en = '1; s_clamp_val = 5'd23;
        @(negedge clk);
        check(s_state == 5'd23, "R4", "clamped S", int'(s_state), 23);
        s_clamp_val = 5'd8;
        @(negedge clk);
        check(s_state == 5'd8, "R4", "re-clamped S", int'(s_state), 8);
        s_clamp_en = '0;

        // R2: forward addition over several operand pairs
        strength = 3'd4;
        forward(10, 13);
        forward(15, 15);
        forward(0, 0);
        forward(7, 9);
        forward(5, 3);

        // R7 and R10: strength zero, free sum bits flip randomly
        strength = 3'd0;
        a_clamp_val = 4'd10; b_clamp_val = 4'd13;
        repeat (100) @(negedge clk);
        chg_on = 1'b1;
        sample_match(300, 23, '1, good);
        chg_on = 1'b0;
        check(good * 10 < 300 * 3, "R7", "sum hits at strength 0", good, 90);
        check(chg_bad == 0, "R10", "min gap between unit changes", chg_min, MIN_GAP);
        check(chg_n > 0, "R10", "free units redraw", chg_n, 1);

        // R6: upper-stage clamp must not disturb lower stages
        strength   = 3'd4;
        a_clamp_val = 4'd1; b_clamp_val = 4'd1;
        s_clamp_en = 5'b10000; s_clamp_val = 5'b10000;
        repeat (300) @(negedge clk);
        sample_match(300, 2, 5'b00111, good);
        check(good * 10 >= 300 * 6, "R6", "low sum bits with carry clamped", good, 180);

        // R5: inverted use, sum clamped to 23
        strength   = 3'd3;
        a_clamp_en = '0; b_clamp_en = '0;
        s_clamp_en = '1; s_clamp_val = 5'd23;
        repeat (300) @(negedge clk);
        sample_inv(1500, cons);
        check(cons * 4 >= 1500, "R5", "samples with A+B=23", cons, 375);
        for (int p = 0; p < 8; p++)
            check(hist[p] > 0, "R5", $sformatf("pair A=%0d B=%0d seen", 8 + p, 15 - p),
                  hist[p], 1);

        // R8: strobe spacing across the whole run
        check(gap_bad == 0, "R8", "strobe spacing", gap_last, SIVL);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule